// File: doc/BRIEF.md
# Memory Decoder Register Bank with Commit Handshake

This block holds the 32-bit configuration registers of a set of host-managed memory address decoders and serves them over a simple little-endian register bus. Each decoder owns a block of seven registers: base low and high, size low and high, control, and target list low and high. The blocks repeat at a fixed stride. A read-only capability word and a two-bit global control word sit below them. Every write is merged through a fixed per-register write mask, so read-only bits keep whatever they hold.

A write to a decoder's control register also acts as a commit handshake. When the commit request bit is set, the decoder is reported as committed. When it is clear, the decoder is reported as not committed. In both cases the error flag is cleared. Only 4-byte aligned accesses to mapped offsets reach the storage. Wider accesses, misaligned accesses and holes in the map read as zero and ignore writes. Read data is registered and appears one cycle after the read strobe.

The block stores configuration and reports status only. It routes no addresses. Software uses it to program the decoder windows, then commits each decoder through its control word.

Top module: `mem_decoder_regbank`

## Requirements
- R1: After reset the capability word (offset 0x00) reads 0x00000312, the global control word (offset 0x04) reads 0, and every decoder register reads 0.
- R2: A 4-byte write stores (wdata AND mask) OR (old AND NOT mask). The mask is 0xF0000000 for base low and size low, 0xFFFFFFFF for base high, size high and target list high, and 0x000013FF for control.
- R3: A write to a decoder control word with bit 9 (commit request) at 1 leaves bit 10 (committed) at 1 and bit 11 (error) at 0.
- R4: A write to a decoder control word with bit 9 at 0 leaves bit 10 at 0 and bit 11 at 0, whatever wdata holds in bits 10 and 11.
- R5: The target list low mask is 0xF0000000 when the parameter ENDPOINT is 1 (the default) and 0xFFFFFFFF when it is 0.
- R6: The capability word ignores all writes. The global control word keeps only bits 1:0 of a write (bit 1 is the decoder enable) and reads 0 in bits 31:2.
- R7: size code 2 selects a 4-byte access, which is served normally. Any other size code (3 is an 8-byte access) reads as 0 and does not change any register.
- R8: An access with addr[1:0] not 0, or to an offset that maps no register, reads as 0 and does not change any register.
- R9: rdata takes the selected value at the clock edge that samples re=1 and holds it while re is 0. A read and a write to the same register in the same cycle return the value before the write.
- R10: Decoder n occupies offsets 0x10 + 0x20*n. Within its block the words at +0x00 to +0x18 are base low, base high, size low, size high, control, target low and target high. Offset +0x1C is a hole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| size | input | 2 | Access size code; 2 means 4 bytes, 3 means 8 bytes |
| rdata | output | 32 | Registered read data |

## Verification
A read and a write can land on the same register in the same cycle. This matters most on a control word, where the write also runs the commit handshake. The bench raises re and we together on each decoder's control word and on masked data words. It expects the pre-write value in rdata on the next cycle and the merged, committed or uncommitted value on a following read. A reference model in the bench evaluates the read before it applies the write and is compared with rdata on every clock.

// File: rtl/mdrb_pkg.sv
package mdrb_pkg;

  localparam int DW         = 32;
  localparam int SLOT_WORDS = 7;

  typedef enum logic [2:0] {
    W_BASE_LO = 3'd0,
    W_BASE_HI = 3'd1,
    W_SIZE_LO = 3'd2,
    W_SIZE_HI = 3'd3,
    W_CTRL    = 3'd4,
    W_TGT_LO  = 3'd5,
    W_TGT_HI  = 3'd6
  } slot_word_e;

  localparam int CTRL_REQ_BIT  = 9;
  localparam int CTRL_DONE_BIT = 10;
  localparam int CTRL_ERR_BIT  = 11;

  localparam logic [1:0] SZ_4B = 2'd2;

  function automatic logic [DW-1:0] slot_wmask(logic [2:0] w, logic endpoint);
    logic [DW-1:0] m;
    case (w)
      W_BASE_LO, W_SIZE_LO: m = 32'hF000_0000;
      W_BASE_HI, W_SIZE_HI,
      W_TGT_HI:             m = 32'hFFFF_FFFF;
      W_CTRL:               m = 32'h0000_13FF;
      W_TGT_LO:             m = endpoint ? 32'hF000_0000 : 32'hFFFF_FFFF;
      default:              m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [3:0] count_code(int n);
    logic [3:0] c;
    if (n <= 1)       c = 4'h0;
    else if (n <= 2)  c = 4'h1;
    else if (n <= 4)  c = 4'h2;
    else if (n <= 6)  c = 4'h3;
    else if (n <= 8)  c = 4'h4;
    else if (n <= 10) c = 4'h5;
    else if (n <= 12) c = 4'h6;
    else if (n <= 14) c = 4'h7;
    else if (n <= 16) c = 4'h8;
    else if (n <= 20) c = 4'h9;
    else if (n <= 24) c = 4'hA;
    else if (n <= 28) c = 4'hB;
    else              c = 4'hC;
    return c;
  endfunction

endpackage

// File: rtl/mdrb_addr_dec.sv
module mdrb_addr_dec #(
  parameter int ADDR_W   = 12,
  parameter int NUM_DEC  = 4,
  parameter int DEC_BASE = 16
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         size,
  output logic               cap_hit,
  output logic               gctl_hit,
  output logic [NUM_DEC-1:0] slot_hit,
  output logic [2:0]         word
);
  import mdrb_pkg::*;

  localparam int WA_W      = ADDR_W - 2;
  localparam int STRIDE_WL = 3;
  localparam logic [WA_W-1:0] BASE_W  = WA_W'(DEC_BASE / 4);
  localparam logic [WA_W-1:0] SPAN_W  = WA_W'(NUM_DEC * (1 << STRIDE_WL));

  logic            acc_ok;
  logic [WA_W-1:0] waddr;
  logic [WA_W-1:0] offw;
  logic            in_dec;
  logic            word_ok;

  always_comb begin
    acc_ok  = (size == SZ_4B) && (addr[1:0] == 2'b00);
    waddr   = addr[ADDR_W-1:2];
    offw    = waddr - BASE_W;
    in_dec  = (waddr >= BASE_W) && (offw < SPAN_W);
    word    = offw[STRIDE_WL-1:0];
    word_ok = (word < 3'(SLOT_WORDS));
    cap_hit  = acc_ok && (waddr == WA_W'(0));
    gctl_hit = acc_ok && (waddr == WA_W'(1));
  end

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_hit
    assign slot_hit[i] = acc_ok && in_dec && word_ok &&
                         (offw[WA_W-1:STRIDE_WL] == (WA_W-STRIDE_WL)'(i));
  end

endmodule

// File: rtl/mdrb_global_regs.sv
module mdrb_global_regs #(
  parameter int NUM_DEC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wdata_lo,
  output logic [31:0] cap_o,
  output logic [31:0] gctl_o
);
  import mdrb_pkg::*;

  localparam logic [3:0] CNT_CODE = count_code(NUM_DEC);

  logic [1:0] gctl_d;
  logic [1:0] gctl_q;

  always_comb begin
    gctl_d = gctl_q;
    if (wr_en) gctl_d = wdata_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     gctl_q <= 2'b00;
    else if (wr_en) gctl_q <= gctl_d;
  end

  // bits: [3:0] count code, [7:4] target count, [8] 256B, [9] 4KiB, [10] poison
  assign cap_o  = {21'd0, 1'b0, 1'b1, 1'b1, 4'h1, CNT_CODE};
  assign gctl_o = {30'd0, gctl_q};

  AST_GCTL_TAKES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> gctl_q == $past(wdata_lo)); // R6

endmodule

// File: rtl/mdrb_decoder_slot.sv
module mdrb_decoder_slot #(
  parameter bit ENDPOINT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  word,
  input  logic [31:0] wdata,
  output logic [31:0] rd_word
);
  import mdrb_pkg::*;

  logic [31:0] regs_q [SLOT_WORDS];
  logic [31:0] regs_d [SLOT_WORDS];
  logic [31:0] mask;
  logic [31:0] merged;

  always_comb begin
    mask   = '0;
    merged = '0;
    for (int w = 0; w < SLOT_WORDS; w++) begin
      regs_d[w] = regs_q[w];
      if (wr_en && (word == 3'(w))) begin
        mask      = slot_wmask(3'(w), ENDPOINT);
        merged    = (wdata & mask) | (regs_q[w] & ~mask);
        regs_d[w] = merged;
        if (3'(w) == W_CTRL) begin
          regs_d[w][CTRL_DONE_BIT] = merged[CTRL_REQ_BIT];
          regs_d[w][CTRL_ERR_BIT]  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < SLOT_WORDS; w++) regs_q[w] <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < SLOT_WORDS; w++) regs_q[w] <= regs_d[w];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < SLOT_WORDS; w++)
      if (word == 3'(w)) rd_word = regs_q[w];
  end

  AST_BASE_LO_RO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && word == W_BASE_LO |=> regs_q[W_BASE_LO][27:0] == $past(regs_q[W_BASE_LO][27:0])); // R2
  AST_COMMIT_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && word == W_CTRL && wdata[CTRL_REQ_BIT]
    |=> regs_q[W_CTRL][CTRL_DONE_BIT] && !regs_q[W_CTRL][CTRL_ERR_BIT]); // R3
  AST_UNCOMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && word == W_CTRL && !wdata[CTRL_REQ_BIT]
    |=> !regs_q[W_CTRL][CTRL_DONE_BIT] && !regs_q[W_CTRL][CTRL_ERR_BIT]); // R4
  AST_IDLE_SLOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> regs_q[W_CTRL] == $past(regs_q[W_CTRL])); // R7

endmodule

// File: rtl/mem_decoder_regbank.sv
module mem_decoder_regbank #(
  parameter int ADDR_W   = 12,
  parameter int NUM_DEC  = 4,
  parameter bit ENDPOINT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              we,
  input  logic              re,
  input  logic [1:0]        size,
  output logic [31:0]       rdata
);
  import mdrb_pkg::*;

  localparam int DEC_BASE = 16;

  logic               cap_hit;
  logic               gctl_hit;
  logic [NUM_DEC-1:0] slot_hit;
  logic [2:0]         word;
  logic [31:0]        cap_v;
  logic [31:0]        gctl_v;
  logic [31:0]        slot_rd [NUM_DEC];
  logic [31:0]        rd_sel;
  logic [31:0]        rdata_d;
  logic [31:0]        rdata_q;
  logic               any_hit;

  mdrb_addr_dec #(
    .ADDR_W  (ADDR_W),
    .NUM_DEC (NUM_DEC),
    .DEC_BASE(DEC_BASE)
  ) u_dec (
    .addr    (addr),
    .size    (size),
    .cap_hit (cap_hit),
    .gctl_hit(gctl_hit),
    .slot_hit(slot_hit),
    .word    (word)
  );

  mdrb_global_regs #(
    .NUM_DEC(NUM_DEC)
  ) u_glb (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (we && gctl_hit),
    .wdata_lo(wdata[1:0]),
    .cap_o   (cap_v),
    .gctl_o  (gctl_v)
  );

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_slot
    mdrb_decoder_slot #(
      .ENDPOINT(ENDPOINT)
    ) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (we && slot_hit[i]),
      .word   (word),
      .wdata  (wdata),
      .rd_word(slot_rd[i])
    );
  end

  always_comb begin
    rd_sel = '0;
    if (cap_hit)  rd_sel = rd_sel | cap_v;
    if (gctl_hit) rd_sel = rd_sel | gctl_v;
    for (int i = 0; i < NUM_DEC; i++)
      if (slot_hit[i]) rd_sel = rd_sel | slot_rd[i];
    any_hit = cap_hit || gctl_hit || (|slot_hit);
    rdata_d = re ? rd_sel : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_hit, gctl_hit, slot_hit})); // R10
  AST_WIDE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    re && size != SZ_4B |=> rdata == 32'd0); // R7
  AST_HOLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    re && !any_hit |=> rdata == 32'd0); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata)); // R9

endmodule

// File: tb/mem_decoder_regbank_tb.sv
module mem_decoder_regbank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NDEC       = 4;

  logic        clk;
  logic        rst_n;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic        we;
  logic        re;
  logic [1:0]  size;
  logic [31:0] rdata;

  int checks;
  int errors;
  int cycles;
  string cur_req;
  string exp_tag;

  // reference model state
  logic [31:0] m_gctl;
  logic [31:0] m_dec [NDEC][7];
  logic [31:0] exp_rdata;

  mem_decoder_regbank u_dut (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (addr),
    .wdata(wdata),
    .we   (we),
    .re   (re),
    .size (size),
    .rdata(rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ref_mask(int w);
    if (w == 0 || w == 2 || w == 5) return 32'hF000_0000;
    if (w == 4) return 32'h0000_13FF;
    return 32'hFFFF_FFFF;
  endfunction

  // returns -1 for no target, -2 cap, -3 gctl, else n*8+w
  function automatic int ref_target(logic [11:0] a, logic [1:0] s);
    int ia;
    ia = int'(a);
    if (s != 2'd2 || (ia % 4) != 0) return -1;
    if (ia == 0) return -2;
    if (ia == 4) return -3;
    if (ia >= 16 && ia < 16 + 32*NDEC) begin
      if (((ia - 16) % 32) / 4 == 7) return -1;
      return ((ia - 16) / 32) * 8 + ((ia - 16) % 32) / 4;
    end
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gctl    = 0;
      exp_rdata = 0;
      for (int n = 0; n < NDEC; n++)
        for (int w = 0; w < 7; w++) m_dec[n][w] = 0;
    end else begin
      int t;
      t = ref_target(addr, size);
      exp_tag = cur_req;
      if (re) begin
        if (t == -2)      exp_rdata = 32'h0000_0312;
        else if (t == -3) exp_rdata = m_gctl;
        else if (t >= 0)  exp_rdata = m_dec[t/8][t%8];
        else              exp_rdata = 0;
      end
      if (we) begin
        if (t == -3) m_gctl = {30'd0, wdata[1:0]};
        else if (t >= 0) begin
          logic [31:0] mk;
          logic [31:0] v;
          mk = ref_mask(t % 8);
          v  = (wdata & mk) | (m_dec[t/8][t%8] & ~mk);
          if (t % 8 == 4) begin
            v[10] = wdata[9];
            v[11] = 1'b0;
          end
          m_dec[t/8][t%8] = v;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rdata !== exp_rdata) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h", exp_tag, rdata, exp_rdata);
      end
    end
  end

  task automatic acc(string req, int a, logic [31:0] d, logic w, logic r, logic [1:0] s);
    @(negedge clk);
    cur_req = req;
    addr  = 12'(a);
    wdata = d;
    we    = w;
    re    = r;
    size  = s;
  endtask

  task automatic idle();
    acc(cur_req, 0, 0, 1'b0, 1'b0, 2'd2);
  endtask

  function automatic int dreg(int n, int w);
    return 16 + 32*n + 4*w;
  endfunction

  initial begin
    int lf;
    checks = 0; errors = 0; cycles = 0;
    cur_req = "R1"; exp_tag = "R1";
    rst_n = 1'b0; addr = 0; wdata = 0; we = 0; re = 0; size = 2'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values, R10 map walk
    acc("R1", 0, 0, 0, 1, 2'd2);
    acc("R1", 4, 0, 0, 1, 2'd2);
    for (int n = 0; n < NDEC; n++)
      for (int w = 0; w < 8; w++) acc("R10", dreg(n, w), 0, 0, 1, 2'd2);

    // R2 / R5: all-ones into every decoder word, then read back
    for (int n = 0; n < NDEC; n++)
      for (int w = 0; w < 7; w++) acc("R2", dreg(n, w), 32'hFFFF_FFFF, 1, 0, 2'd2);
    for (int n = 0; n < NDEC; n++)
      for (int w = 0; w < 7; w++) acc(w == 5 ? "R5" : "R2", dreg(n, w), 0, 0, 1, 2'd2);
    for (int n = 0; n < NDEC; n++) acc("R2", dreg(n, 0), 32'h5A5A_5A5A, 1, 1, 2'd2);
    for (int n = 0; n < NDEC; n++) acc("R2", dreg(n, 0), 0, 0, 1, 2'd2);

    // R3 commit, R4 uncommit on each decoder, with bits 10/11 driven
    for (int n = 0; n < NDEC; n++) begin
      acc("R3", dreg(n, 4), 32'h0000_02AB, 1, 0, 2'd2);
      acc("R3", dreg(n, 4), 0, 0, 1, 2'd2);
      acc("R4", dreg(n, 4), 32'h0000_0CCD, 1, 0, 2'd2);
      acc("R4", dreg(n, 4), 0, 0, 1, 2'd2);
      acc("R3", dreg(n, 4), 32'hFFFF_FFFF, 1, 0, 2'd2);
      acc("R3", dreg(n, 4), 0, 0, 1, 2'd2);
    end

    // R9: read and write same control word in one cycle
    for (int n = 0; n < NDEC; n++) begin
      acc("R9", dreg(n, 4), 32'h0000_0011, 1, 1, 2'd2);
      acc("R9", dreg(n, 4), 32'h0000_0200, 1, 1, 2'd2);
      acc("R9", dreg(n, 4), 0, 0, 1, 2'd2);
    end
    acc("R9", dreg(1, 1), 32'h1234_5678, 1, 1, 2'd2);
    repeat (3) idle();

    // R6 capability read-only, global control masked
    acc("R6", 0, 32'hFFFF_FFFF, 1, 0, 2'd2);
    acc("R6", 0, 0, 0, 1, 2'd2);
    acc("R6", 4, 32'hFFFF_FFFE, 1, 0, 2'd2);
    acc("R6", 4, 0, 0, 1, 2'd2);
    acc("R6", 4, 32'h0000_0001, 1, 1, 2'd2);
    acc("R6", 4, 0, 0, 1, 2'd2);

    // R7 wide and other size codes
    acc("R7", dreg(2, 1), 32'hDEAD_BEEF, 1, 0, 2'd3);
    acc("R7", dreg(2, 1), 0, 0, 1, 2'd3);
    acc("R7", dreg(2, 1), 0, 0, 1, 2'd2);
    acc("R7", dreg(2, 4), 32'h0000_0000, 1, 0, 2'd1);
    acc("R7", dreg(2, 4), 0, 0, 1, 2'd2);
    acc("R7", 4, 32'h0, 1, 0, 2'd0);
    acc("R7", 4, 0, 0, 1, 2'd2);

    // R8 misaligned and holes
    acc("R8", dreg(3, 1) + 1, 32'h0BAD_0BAD, 1, 1, 2'd2);
    acc("R8", dreg(3, 1), 0, 0, 1, 2'd2);
    acc("R8", dreg(3, 7), 32'hFFFF_FFFF, 1, 1, 2'd2);
    acc("R8", 8, 32'hFFFF_FFFF, 1, 1, 2'd2);
    acc("R8", 16 + 32*NDEC, 32'hFFFF_FFFF, 1, 1, 2'd2);
    acc("R8", 4, 32'h0000_0002, 1, 1, 2'd2);
    acc("R8", 4 + 2, 32'h0000_0000, 1, 0, 2'd2);
    acc("R8", 4, 0, 0, 1, 2'd2);

    // mixed pattern
    lf = 32'h1ACE;
    for (int k = 0; k < 400; k++) begin
      int a;
      lf = (lf << 1) ^ (((lf >> 15) ^ (lf >> 13)) & 1) ^ k;
      lf = lf & 32'hFFFF;
      a  = (lf % 44) * 4;
      if ((lf & 32'h300) == 32'h300) a = a + 2;
      acc((a % 32 == 0) ? "R3" : "R2", a, {lf[15:0], lf[7:0], lf[15:8]},
          lf[4], lf[5] | lf[6], (lf[12:10] == 3'd7) ? 2'd3 : 2'd2);
    end
    repeat (2) idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule